// File: doc/BRIEF.md
# Register-Controlled Barrel Shifter with Carry

This block shifts or rotates a 32-bit operand by an amount taken from a general register. It supports four operations: logical left, logical right, arithmetic right and rotate right. It returns both the shifted value and an updated carry flag. Only the bottom byte of the amount word counts. That makes amounts from 0 to 255 possible. Amounts at or beyond the operand width do not wrap. Each shift kind gives a defined result and carry for them, and rotate alone reduces its amount modulo the width.

The block is purely combinational. A data-processing stage feeds it the operand, the amount register, a two-bit operation select and the current carry flag. It takes the result and the new carry in the same cycle.

Top module: `reg_shifter`

## Requirements
- R1: Only amount bits [7:0] affect the outputs; bits [31:8] of the amount word are ignored.
- R2: The operation select encodes 0 = logical left, 1 = logical right, 2 = arithmetic right, 3 = rotate right. An effective amount of 0 gives result = operand and carry = incoming carry for all four encodings.
- R3: Logical left by n in 1..31 gives operand << n with zeros shifted in, and the carry is operand bit (32-n).
- R4: Logical left by exactly 32 gives result 0 and carry = operand bit 0. Logical left by 33..255 gives result 0 and carry 0.
- R5: Logical right by n in 1..31 gives operand >> n with zeros shifted in, and the carry is operand bit (n-1).
- R6: Logical right by exactly 32 gives result 0 and carry = operand bit 31. Logical right by 33..255 gives result 0 and carry 0.
- R7: Arithmetic right by n in 1..31 fills with operand bit 31, and the carry is operand bit (n-1). Arithmetic right by 32..255 gives every result bit and the carry equal to operand bit 31.
- R8: Rotate right uses the amount modulo 32. For a nonzero amount, the carry is bit 31 of the rotated result. When the amount is nonzero but a multiple of 32, the result equals the operand and the carry is operand bit 31.
- R9: The outputs depend only on the present inputs, with no storage and no clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | 32 | Value to shift or rotate |
| amt_i | input | 32 | Amount register; only bits [7:0] are used |
| kind_i | input | 2 | Operation select (0 LSL, 1 LSR, 2 ASR, 3 ROR) |
| carry_i | input | 1 | Incoming carry flag |
| result_o | output | 32 | Shifted or rotated value |
| carry_o | output | 1 | New carry flag |

## Verification
Both results are due in the same cycle the inputs change, because there is no register anywhere between ports. The bench therefore applies each input set, waits a short settling delay inside the same clock period, and compares before it drives the next set. It sweeps every effective amount from 0 to 255 for all four kinds, several operands and both carry values. The upper amount bits are filled with varying junk. The expected values come from a model that performs the operation one bit step at a time.

// File: rtl/reg_shifter.sv
module reg_shifter #(
  parameter int WIDTH    = 32,
  parameter int AMT_BITS = 8
) (
  input  logic [WIDTH-1:0] opnd_i,
  input  logic [WIDTH-1:0] amt_i,
  input  logic [1:0]       kind_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] result_o,
  output logic             carry_o
);
  localparam int SHW = $clog2(WIDTH);

  logic [AMT_BITS-1:0] amt;
  logic [SHW-1:0]      lo;
  logic                zero_amt, at_width, past_width;

  assign amt        = amt_i[AMT_BITS-1:0];
  assign lo         = amt[SHW-1:0];
  assign zero_amt   = (amt == '0);
  assign at_width   = (amt == AMT_BITS'(WIDTH));
  assign past_width = (amt > AMT_BITS'(WIDTH));

  logic [WIDTH:0]          lsl_w, lsr_w;
  logic signed [WIDTH:0]   asr_w;
  logic [2*WIDTH-1:0]      ror_w;

  assign lsl_w = {1'b0, opnd_i} << lo;
  assign lsr_w = {opnd_i, 1'b0} >> lo;
  assign asr_w = $signed({opnd_i, 1'b0}) >>> lo;
  assign ror_w = {opnd_i, opnd_i} >> lo;

  logic unused_bits;
  assign unused_bits = ^{amt_i[WIDTH-1:AMT_BITS], ror_w[2*WIDTH-1:WIDTH]};

  logic msb;
  assign msb = opnd_i[WIDTH-1];

  always_comb begin
    result_o = opnd_i;
    carry_o  = carry_i;
    if (!zero_amt) begin
      unique case (kind_i)
        2'd0: begin
          if (at_width) begin
            result_o = '0;
            carry_o  = opnd_i[0];
          end else if (past_width) begin
            result_o = '0;
            carry_o  = 1'b0;
          end else begin
            result_o = lsl_w[WIDTH-1:0];
            carry_o  = lsl_w[WIDTH];
          end
        end
        2'd1: begin
          if (at_width) begin
            result_o = '0;
            carry_o  = msb;
          end else if (past_width) begin
            result_o = '0;
            carry_o  = 1'b0;
          end else begin
            result_o = lsr_w[WIDTH:1];
            carry_o  = lsr_w[0];
          end
        end
        2'd2: begin
          if (at_width || past_width) begin
            result_o = {WIDTH{msb}};
            carry_o  = msb;
          end else begin
            result_o = asr_w[WIDTH:1];
            carry_o  = asr_w[0];
          end
        end
        default: begin
          result_o = ror_w[WIDTH-1:0];
          carry_o  = ror_w[WIDTH-1];
        end
      endcase
    end
  end
endmodule

// File: rtl/reg_shifter_chk.sv
module reg_shifter_chk #(
  parameter int WIDTH    = 32,
  parameter int AMT_BITS = 8
) (
  input logic [WIDTH-1:0] opnd_i,
  input logic [WIDTH-1:0] amt_i,
  input logic [1:0]       kind_i,
  input logic             carry_i,
  input logic [WIDTH-1:0] result_o,
  input logic             carry_o
);
  logic [AMT_BITS-1:0] a;
  assign a = amt_i[AMT_BITS-1:0];

  always_comb begin
    if (a == '0) begin
      a_r2_zero_passthru: assert (result_o == opnd_i && carry_o == carry_i)
        else $error("zero amount altered outputs");
    end
    if (kind_i inside {2'd0, 2'd1} && a > AMT_BITS'(WIDTH)) begin
      a_r4_r6_far_clear: assert (result_o == '0 && carry_o == 1'b0)
        else $error("far logical shift not cleared");
    end
    if (kind_i == 2'd2 && a >= AMT_BITS'(WIDTH)) begin
      a_r7_sign_fill: assert (result_o == {WIDTH{opnd_i[WIDTH-1]}} && carry_o == opnd_i[WIDTH-1])
        else $error("arithmetic shift not sign filled");
    end
    if (kind_i == 2'd3) begin
      a_r8_rotate_keeps_ones: assert ($countones(result_o) == $countones(opnd_i))
        else $error("rotate changed population");
    end
    if (kind_i == 2'd3 && a != '0) begin
      a_r8_rotate_carry: assert (carry_o == result_o[WIDTH-1])
        else $error("rotate carry mismatch");
    end
  end
endmodule

bind reg_shifter reg_shifter_chk #(.WIDTH(WIDTH), .AMT_BITS(AMT_BITS)) chk_i (
  .opnd_i(opnd_i), .amt_i(amt_i), .kind_i(kind_i), .carry_i(carry_i),
  .result_o(result_o), .carry_o(carry_o)
);

// File: tb/reg_shifter_tb.sv
`timescale 1ns/1ps
module reg_shifter_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [31:0] opnd, amt, res;
  logic [1:0]  kind;
  logic        cin, cout;
  int n_chk = 0, n_bad = 0, cyc = 0;

  reg_shifter dut_i (.opnd_i(opnd), .amt_i(amt), .kind_i(kind), .carry_i(cin),
                     .result_o(res), .carry_o(cout));

  task automatic model(input logic [31:0] v0, input int n, input logic [1:0] k,
                       input logic c0, output logic [31:0] v, output logic c);
    v = v0; c = c0;
    if (k == 2'd3) begin
      for (int i = 0; i < n % 32; i++) v = {v[0], v[31:1]};
      if (n != 0) c = v[31];
    end else begin
      for (int i = 0; i < n; i++) begin
        case (k)
          2'd0: begin c = v[31]; v = {v[30:0], 1'b0}; end
          2'd1: begin c = v[0];  v = {1'b0, v[31:1]}; end
          default: begin c = v[0]; v = {v[31], v[31:1]}; end
        endcase
      end
    end
  endtask

  function automatic string tag(input logic [1:0] k, input int n);
    if (n == 0) return "R2";
    case (k)
      2'd0: return (n < 32) ? "R3" : "R4";
      2'd1: return (n < 32) ? "R5" : "R6";
      2'd2: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string r, input logic [31:0] er, input logic ec);
    n_chk++;
    if (res !== er || cout !== ec) begin
      n_bad++;
      $display("FAIL %s: op=%h amt=%h kind=%0d cin=%b got %h/%b expected %h/%b",
               r, opnd, amt, kind, cin, res, cout, er, ec);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] ops [6];
    logic [31:0] er;
    logic        ec;
    ops = '{32'h8000_0001, 32'h7FFF_FFFE, 32'hDEAD_BEEF,
            32'h1234_5678, 32'hFFFF_FFFF, 32'h0000_0000};
    opnd = '0; amt = '0; kind = '0; cin = 1'b0;
    #2;
    check("R2 idle", 32'h0, 1'b0);

    // R9: outputs compared within the same period as the input change
    for (int k = 0; k < 4; k++)
      for (int o = 0; o < 6; o++)
        for (int c = 0; c < 2; c++)
          for (int n = 0; n < 256; n++) begin
            opnd = ops[o]; kind = 2'(k); cin = c[0];
            amt = {24'(n * 32'h9E37 + o * 7 + k), 8'(n)};
            #1;
            model(opnd, n, kind, cin, er, ec);
            check(tag(kind, n), er, ec);
          end

    // R1: upper amount bits alone must not change anything
    for (int k = 0; k < 4; k++)
      for (int j = 0; j < 8; j++) begin
        opnd = 32'hC3A5_0F81; kind = 2'(k); cin = 1'b1;
        amt = {24'hFFFFFF >> j, 8'd0};
        #1; check("R1", opnd, 1'b1);
        amt = {24'h800000 >> j, 8'd5};
        #1; model(opnd, 5, kind, 1'b1, er, ec); check("R1", er, ec);
      end

    // explicit boundary points
    opnd = 32'h8000_0001; cin = 1'b0;
    kind = 2'd0; amt = 32'd32; #1; check("R4 lsl32", 32'h0, 1'b1);
    kind = 2'd0; amt = 32'd33; #1; check("R4 lsl33", 32'h0, 1'b0);
    kind = 2'd1; amt = 32'd32; #1; check("R6 lsr32", 32'h0, 1'b1);
    kind = 2'd1; amt = 32'd1;  #1; check("R5 lsr1", 32'h4000_0000, 1'b1);
    kind = 2'd0; amt = 32'd31; #1; check("R3 lsl31", 32'h8000_0000, 1'b0);
    kind = 2'd2; amt = 32'd200;#1; check("R7 asr200", 32'hFFFF_FFFF, 1'b1);
    kind = 2'd3; amt = 32'd64; #1; check("R8 ror64", 32'h8000_0001, 1'b1);
    kind = 2'd3; amt = 32'd1;  #1; check("R8 ror1", 32'hC000_0000, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule